// File: doc/BRIEF.md
# Partitioned decimal address generator

This block turns one operand address of a decimal, character-addressed instruction into an absolute store address. The operand arrives as four BCD digits, three encoded page bits, a flag that picks the shared Common area or the running partition, an index-register selector, an indirect flag and an extended-indexing flag. The block can fetch a four-character indirect word and a four-character index register over a simple request/valid port. It adds the index in decimal and relocates partition addresses past Common and all lower partitions. It reports exactly one outcome per request: a finished address, a program check or an address check.

Configuration comes in as binary location counts: the Common size, the base of the running partition (the summed sizes of every lower-numbered partition) and the partition size. These inputs are expected to stay stable while a request is in flight. A request is taken only while the block is idle. An indirect word is resolved before any index is added, and only one level of indirection is followed.

Top module: `dec_addr_gen`

## Requirements
- R1: After reset, valid_o, done_o, pchk_o, achk_o and mem_req_o are all 0.
- R2: Any operand digit above 9 ends the request with pchk_o and no memory fetch.
- R3: The decoded page is formed from page_i inverted, with page_i[2] weighted 1, page_i[1] weighted 2 and page_i[0] weighted 4. The offset is page*10000 plus the decimal value of the digits, and a Common address (common_i=1) reports this offset unchanged as abs_o.
- R4: A partition address (common_i=0) reports abs_o = common_size_i + part_base_i + offset.
- R5: An effective offset at or above the region size (common_size_i for Common, part_size_i for a partition) gives achk_o.
- R6: A write (write_i=1) whose effective Common offset is below 300 gives pchk_o. A read of the same location completes.
- R7: A non-zero idx_sel_i fetches the word at partition offset 10*idx_sel_i+1 and adds its digits in BCD. A carry out of the top digit raises the page by one.
- R8: With ext_n_i=0 the decoded page of the index word is added to the page. With ext_n_i=1 the index page is ignored.
- R9: With indirect_i=1 the word at the operand address is fetched first. Its digits, the page from the inverted bit 4 of characters 1 to 3 (character 1 weighted 1), and its mode from bit 5 of character 4 replace the operand fields before indexing. Words arrive with character 1 in mem_data_i[23:18] and the numeric digit in bits [3:0] of each character.
- R10: A digit above 9 in a fetched indirect or index word gives pchk_o.
- R11: Each request ends with a one-cycle valid_o carrying exactly one of done_o, pchk_o, achk_o. mem_req_o holds with a stable mem_addr_o until mem_valid_i.
- R12: An indirect pointer whose fourth character would lie at or beyond the region size gives achk_o with no fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a request (taken while idle) |
| digits_i | input | 16 | Four BCD operand digits, most significant first |
| page_i | input | 3 | Encoded page bits |
| common_i | input | 1 | 1 = Common, 0 = partition |
| idx_sel_i | input | 2 | Index register select, 0 = none |
| indirect_i | input | 1 | Resolve through an indirect word |
| ext_n_i | input | 1 | 0 = include index page bits |
| write_i | input | 1 | Operand is a write target |
| common_size_i | input | 18 | Common size in locations |
| part_base_i | input | 18 | Summed size of lower partitions |
| part_size_i | input | 18 | Running partition size |
| mem_req_o | output | 1 | Word fetch request |
| mem_addr_o | output | 18 | Absolute address of the word |
| mem_valid_i | input | 1 | Word data valid |
| mem_data_i | input | 24 | Four fetched characters |
| valid_o | output | 1 | Result pulse |
| done_o | output | 1 | Address formed |
| pchk_o | output | 1 | Program check |
| achk_o | output | 1 | Address check |
| abs_o | output | 18 | Absolute address |

## Verification
The plain sweep drives all eight encoded pages, both areas, reads and writes, and digit patterns that sit on either side of the 300 protection limit and the region ends. This separates a page decode error from a relocation or a bound error. Index runs use words that cause a decimal carry into the next page and words that carry page bits, each with the extended flag on and off. This shows whether the carry and the page contribution are added. Indirect runs switch the mode between Common and partition, combine indirect with indexing, and put pointers one location inside and at the region end. Words with bad digits check the ordering of the program check. The bench also checks the address and the number of fetches on each run.

// File: rtl/adg_pkg.sv
package adg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_IND,
    ST_IDX,
    ST_FIN
  } adg_state_e;

  typedef enum logic [1:0] {
    RES_DONE,
    RES_PCHK,
    RES_ACHK
  } adg_res_e;
endpackage

// File: rtl/adg_bcd_check.sv
module adg_bcd_check #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] digits_i,
  output logic                bad_o
);
  logic [DIGITS-1:0] bad;
  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    assign bad[g] = digits_i[4*g +: 4] > 4'd9;
  end
  assign bad_o = |bad;
endmodule

// File: rtl/adg_bcd_add.sv
module adg_bcd_add #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] a_i,
  input  logic [4*DIGITS-1:0] b_i,
  output logic [4*DIGITS-1:0] sum_o,
  output logic                carry_o
);
  logic [DIGITS:0] cy;
  assign cy[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [4:0] raw;
    always_comb begin
      raw = {1'b0, a_i[4*g +: 4]} + {1'b0, b_i[4*g +: 4]} + {4'b0, cy[g]};
      if (raw > 5'd9) begin
        sum_o[4*g +: 4] = 4'(raw - 5'd10);
        cy[g+1]         = 1'b1;
      end else begin
        sum_o[4*g +: 4] = raw[3:0];
        cy[g+1]         = 1'b0;
      end
    end
  end
  assign carry_o = cy[DIGITS];
endmodule

// File: rtl/adg_locate.sv
module adg_locate #(
  parameter int DIGITS = 4,
  parameter int PW     = 4,
  parameter int AW     = 18
) (
  input  logic [PW-1:0]       page_i,
  input  logic [4*DIGITS-1:0] digits_i,
  input  logic                common_i,
  input  logic [AW-1:0]       common_size_i,
  input  logic [AW-1:0]       part_base_i,
  output logic [AW-1:0]       off_o,
  output logic [AW-1:0]       abs_o
);
  localparam int SPAN = 10 ** DIGITS;

  always_comb begin
    off_o = '0;
    for (int i = 0; i < DIGITS; i++) begin
      off_o = off_o * AW'(10) + AW'(digits_i[4*(DIGITS-1-i) +: 4]);
    end
    off_o = off_o + AW'(page_i) * AW'(SPAN);
    abs_o = common_i ? off_o : common_size_i + part_base_i + off_o;
  end
endmodule

// File: rtl/dec_addr_gen.sv
module dec_addr_gen
  import adg_pkg::*;
#(
  parameter int DIGITS     = 4,
  parameter int PAGE_W     = 3,
  parameter int AW         = 18,
  parameter int CHAR_W     = 6,
  parameter int PROT_LIMIT = 300
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic [4*DIGITS-1:0]     digits_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic                    common_i,
  input  logic [1:0]              idx_sel_i,
  input  logic                    indirect_i,
  input  logic                    ext_n_i,
  input  logic                    write_i,
  input  logic [AW-1:0]           common_size_i,
  input  logic [AW-1:0]           part_base_i,
  input  logic [AW-1:0]           part_size_i,
  output logic                    mem_req_o,
  output logic [AW-1:0]           mem_addr_o,
  input  logic                    mem_valid_i,
  input  logic [DIGITS*CHAR_W-1:0] mem_data_i,
  output logic                    valid_o,
  output logic                    done_o,
  output logic                    pchk_o,
  output logic                    achk_o,
  output logic [AW-1:0]           abs_o
);
  localparam int DW     = 4 * DIGITS;
  localparam int WORD_W = DIGITS * CHAR_W;
  localparam int PW     = PAGE_W + 1;
  localparam int LAST   = 3;  // offset of last character of a word

  adg_state_e        st_q;
  logic [DW-1:0]     dig_q, idx_dig_q;
  logic [PAGE_W-1:0] pg_q, idx_pg_q;
  logic              com_q, ind_q, ext_n_q, wr_q;
  logic [1:0]        sel_q;

  // operand page decode: inverted, leftmost bit weight 1
  logic [PAGE_W-1:0] op_pg;
  for (genvar i = 0; i < PAGE_W; i++) begin : g_op_pg
    assign op_pg[i] = ~page_i[PAGE_W-1-i];
  end

  // fetched word unpack
  logic [DW-1:0]     w_dig;
  logic [PAGE_W-1:0] w_pg;
  logic              w_mode;
  for (genvar k = 0; k < DIGITS; k++) begin : g_word
    localparam int TOP = WORD_W - 1 - k * CHAR_W;
    assign w_dig[4*(DIGITS-1-k) +: 4] = mem_data_i[TOP-CHAR_W+4 -: 4];
    if (k < PAGE_W) begin : g_pg
      assign w_pg[k] = ~mem_data_i[TOP-1];
    end
  end
  assign w_mode = mem_data_i[CHAR_W-1];

  logic bad_op, bad_word;
  adg_bcd_check #(.DIGITS(DIGITS)) u_chk_op (.digits_i(dig_q),  .bad_o(bad_op));
  adg_bcd_check #(.DIGITS(DIGITS)) u_chk_wd (.digits_i(w_dig),  .bad_o(bad_word));

  logic [DW-1:0] sum;
  logic          carry;
  adg_bcd_add #(.DIGITS(DIGITS)) u_add (
    .a_i(dig_q), .b_i(idx_dig_q), .sum_o(sum), .carry_o(carry)
  );

  logic [PW-1:0] fin_pg;
  assign fin_pg = PW'(pg_q) + (ext_n_q ? PW'(0) : PW'(idx_pg_q)) + PW'(carry);

  logic [AW-1:0] ptr_off, ptr_abs, fin_off, fin_abs;
  adg_locate #(.DIGITS(DIGITS), .PW(PW), .AW(AW)) u_loc_ptr (
    .page_i({1'b0, pg_q}), .digits_i(dig_q), .common_i(com_q),
    .common_size_i(common_size_i), .part_base_i(part_base_i),
    .off_o(ptr_off), .abs_o(ptr_abs)
  );
  adg_locate #(.DIGITS(DIGITS), .PW(PW), .AW(AW)) u_loc_fin (
    .page_i(fin_pg), .digits_i(sum), .common_i(com_q),
    .common_size_i(common_size_i), .part_base_i(part_base_i),
    .off_o(fin_off), .abs_o(fin_abs)
  );

  logic [AW-1:0] region, idx_off, idx_abs;
  assign region  = com_q ? common_size_i : part_size_i;
  assign idx_off = AW'(sel_q) * AW'(10) + AW'(1);
  assign idx_abs = common_size_i + part_base_i + idx_off;

  assign mem_req_o  = (st_q == ST_IND) || (st_q == ST_IDX);
  assign mem_addr_o = (st_q == ST_IDX) ? idx_abs : ptr_abs;

  logic     fin_now;
  adg_res_e fin_res;
  always_comb begin
    fin_now = 1'b0;
    fin_res = RES_DONE;
    unique case (st_q)
      ST_START: begin
        if (bad_op) begin
          fin_now = 1'b1; fin_res = RES_PCHK;
        end else if (ind_q) begin
          if (ptr_off + AW'(LAST) >= region) begin
            fin_now = 1'b1; fin_res = RES_ACHK;
          end
        end else if (sel_q != 2'd0) begin
          if (idx_off + AW'(LAST) >= part_size_i) begin
            fin_now = 1'b1; fin_res = RES_ACHK;
          end
        end
      end
      ST_IDX: begin
        if (mem_valid_i && bad_word) begin
          fin_now = 1'b1; fin_res = RES_PCHK;
        end
      end
      ST_FIN: begin
        fin_now = 1'b1;
        if (fin_off >= region)                                  fin_res = RES_ACHK;
        else if (com_q && wr_q && fin_off < AW'(PROT_LIMIT))    fin_res = RES_PCHK;
        else                                                    fin_res = RES_DONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      dig_q     <= '0;
      idx_dig_q <= '0;
      pg_q      <= '0;
      idx_pg_q  <= '0;
      com_q     <= 1'b0;
      ind_q     <= 1'b0;
      ext_n_q   <= 1'b1;
      wr_q      <= 1'b0;
      sel_q     <= '0;
      valid_o   <= 1'b0;
      done_o    <= 1'b0;
      pchk_o    <= 1'b0;
      achk_o    <= 1'b0;
      abs_o     <= '0;
    end else begin
      valid_o <= fin_now;
      done_o  <= fin_now && (fin_res == RES_DONE);
      pchk_o  <= fin_now && (fin_res == RES_PCHK);
      achk_o  <= fin_now && (fin_res == RES_ACHK);
      if (fin_now && fin_res == RES_DONE) abs_o <= fin_abs;

      if (fin_now) begin
        st_q <= ST_IDLE;
      end else begin
        unique case (st_q)
          ST_IDLE: if (req_i) begin
            dig_q     <= digits_i;
            pg_q      <= op_pg;
            com_q     <= common_i;
            sel_q     <= idx_sel_i;
            ind_q     <= indirect_i;
            ext_n_q   <= ext_n_i;
            wr_q      <= write_i;
            idx_dig_q <= '0;
            idx_pg_q  <= '0;
            st_q      <= ST_START;
          end
          ST_START: begin
            if (ind_q)                 st_q <= ST_IND;
            else if (sel_q != 2'd0)    st_q <= ST_IDX;
            else                       st_q <= ST_FIN;
          end
          ST_IND: if (mem_valid_i) begin
            dig_q <= w_dig;
            pg_q  <= w_pg;
            com_q <= w_mode;
            ind_q <= 1'b0;
            st_q  <= ST_START;  // re-check digits, then index
          end
          ST_IDX: if (mem_valid_i) begin
            idx_dig_q <= w_dig;
            idx_pg_q  <= w_pg;
            st_q      <= ST_FIN;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adg_assert.sv
module adg_assert #(
  parameter int AW = 18
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_valid_i,
  input logic          valid_o,
  input logic          done_o,
  input logic          pchk_o,
  input logic          achk_o
);
  // R11
  one_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones({done_o, pchk_o, achk_o}) == 1);

  // R11
  quiet_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(done_o || pchk_o || achk_o));

  // R11
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R11
  hold_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R11
  no_fetch_on_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !mem_req_o);
endmodule

bind dec_addr_gen adg_assert #(.AW(AW)) u_adg_assert (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_valid_i(mem_valid_i), .valid_o(valid_o), .done_o(done_o),
  .pchk_o(pchk_o), .achk_o(achk_o)
);

// File: tb/dec_addr_gen_test.sv
`timescale 1ns/1ps
module dec_addr_gen_test;
  localparam int C_SZ = 20000;
  localparam int P_BASE = 15000;
  localparam int P_SZ = 30000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [15:0] digits_i = '0;
  logic [2:0]  page_i = '0;
  logic        common_i = 1'b0;
  logic [1:0]  idx_sel_i = '0;
  logic        indirect_i = 1'b0;
  logic        ext_n_i = 1'b1;
  logic        write_i = 1'b0;
  logic [17:0] common_size_i = 18'(C_SZ);
  logic [17:0] part_base_i = 18'(P_BASE);
  logic [17:0] part_size_i = 18'(P_SZ);
  logic        mem_req_o;
  logic [17:0] mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [23:0] mem_data_i = '0;
  logic        valid_o, done_o, pchk_o, achk_o;
  logic [17:0] abs_o;

  dec_addr_gen uut (.*);

  always #2.5 clk_i = ~clk_i;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // word contents served by the bench memory
  logic [15:0] ind_dig = '0;
  int          ind_pg = 0;
  bit          ind_mode = 0;
  logic [15:0] idx_dig = '0;
  int          idx_pg = 0;

  // expected outcome: 0 done, 1 program check, 2 address check
  int e_kind, e_abs, e_nf;
  int e_fa [2];

  task automatic check(string tag, int act, int exp, string what);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int val4(logic [15:0] d);
    return int'(d[15:12]) * 1000 + int'(d[11:8]) * 100 + int'(d[7:4]) * 10 + int'(d[3:0]);
  endfunction

  function automatic bit bad4(logic [15:0] d);
    return d[15:12] > 9 || d[11:8] > 9 || d[7:4] > 9 || d[3:0] > 9;
  endfunction

  function automatic logic [23:0] mkw(logic [15:0] d, int pg, bit mode);
    logic [2:0] p = 3'(pg);
    return {1'b0, ~p[0], d[15:12], 1'b0, ~p[1], d[11:8],
            1'b0, ~p[2], d[7:4], mode, 1'b0, d[3:0]};
  endfunction

  task automatic model(bit com, int p, logic [15:0] dig, int sel, bit ind, bit ext_n, bit wr);
    logic [15:0] cd = dig;
    int cp = p;
    bit cc = com;
    int s, off, size;
    e_nf = 0; e_abs = 0; e_kind = 0;
    if (bad4(dig)) begin e_kind = 1; return; end
    if (ind) begin
      size = cc ? C_SZ : P_SZ;
      off = cp * 10000 + val4(cd);
      if (off + 3 >= size) begin e_kind = 2; return; end
      e_fa[0] = cc ? off : C_SZ + P_BASE + off;
      e_nf = 1;
      cd = ind_dig; cp = ind_pg; cc = ind_mode;
      if (bad4(cd)) begin e_kind = 1; return; end
    end
    s = val4(cd);
    if (sel != 0) begin
      e_fa[e_nf] = C_SZ + P_BASE + 10 * sel + 1;
      e_nf = e_nf + 1;
      if (bad4(idx_dig)) begin e_kind = 1; return; end
      s = s + val4(idx_dig);
      if (s >= 10000) begin s = s - 10000; cp = cp + 1; end
      if (!ext_n) cp = cp + idx_pg;
    end
    off = cp * 10000 + s;
    size = cc ? C_SZ : P_SZ;
    if (off >= size) e_kind = 2;
    else if (cc && wr && off < 300) e_kind = 1;
    else begin e_kind = 0; e_abs = cc ? off : C_SZ + P_BASE + off; end
  endtask

  task automatic run(string tag, bit com, int p, logic [15:0] dig, int sel, bit ind,
                     bit ext_n, bit wr);
    logic [2:0] pp = 3'(p);
    int nf = 0;
    bit got = 0;
    int act;
    model(com, p, dig, sel, ind, ext_n, wr);
    @(negedge clk_i);
    digits_i = dig; page_i = {~pp[0], ~pp[1], ~pp[2]}; common_i = com;
    idx_sel_i = 2'(sel); indirect_i = ind; ext_n_i = ext_n; write_i = wr;
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    for (int t = 0; t < 200 && !got; t++) begin
      if (valid_o) got = 1;
      else if (mem_req_o) begin
        if (nf < e_nf) check(tag, int'(mem_addr_o), e_fa[nf], "fetch address");
        else check(tag, nf + 1, e_nf, "fetch count");
        @(negedge clk_i);
        mem_data_i = (ind && nf == 0) ? mkw(ind_dig, ind_pg, ind_mode) : mkw(idx_dig, idx_pg, 1'b0);
        mem_valid_i = 1'b1;
        @(negedge clk_i);
        mem_valid_i = 1'b0;
        nf = nf + 1;
      end else @(negedge clk_i);
    end
    if (!got) begin
      check(tag, 0, 1, "result timeout");
      return;
    end
    act = done_o ? 0 : pchk_o ? 1 : achk_o ? 2 : 3;
    check(tag, act, e_kind, "outcome");
    check(tag, nf, e_nf, "fetches");
    if (e_kind == 0 && act == 0) check(tag, int'(abs_o), e_abs, "abs");
  endtask

  initial begin
    logic [15:0] pats [5] = '{16'h0000, 16'h0299, 16'h0300, 16'h5000, 16'h9999};
    logic [15:0] bads [4] = '{16'hA000, 16'h0B00, 16'h00C0, 16'h999F};
    logic [15:0] ixd  [4] = '{16'h0050, 16'h9999, 16'h2345, 16'h0000};
    int          ixp  [4] = '{0, 0, 1, 3};

    #12;
    @(negedge clk_i);
    // R1 reset state
    check("R1", int'({valid_o, done_o, pchk_o, achk_o, mem_req_o}), 0, "reset outputs");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", int'({valid_o, mem_req_o}), 0, "idle after reset");

    // R3 R4 R5 R6 plain sweep over pages, areas, access kind
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 2; c++)
        for (int w = 0; w < 2; w++)
          for (int d = 0; d < 5; d++)
            run(c ? "R3_R5_R6" : "R4_R5", c[0], p, pats[d], 0, 1'b0, 1'b1, w[0]);

    // R2 bad operand digits, even with indirect and index requested
    for (int b = 0; b < 4; b++) begin
      run("R2", 1'b0, 0, bads[b], 2, 1'b1, 1'b0, 1'b0);
      run("R2", 1'b1, 1, bads[b], 0, 1'b0, 1'b1, 1'b1);
    end

    // R7 R8 indexing with carries and page bits
    for (int s = 1; s < 4; s++)
      for (int i = 0; i < 4; i++)
        for (int e = 0; e < 2; e++) begin
          idx_dig = ixd[i]; idx_pg = ixp[i];
          run(e ? "R7" : "R8", 1'b0, 1, 16'h2000, s, 1'b0, e[0], 1'b0);
          run(e ? "R7" : "R8", 1'b0, 0, 16'h7777, s, 1'b0, e[0], 1'b0);
          run(e ? "R7" : "R8", 1'b1, 0, 16'h9990, s, 1'b0, e[0], 1'b1);
        end

    // R9 indirect resolution, mode switch, then indexing
    ind_dig = 16'h4321; ind_pg = 1; ind_mode = 0;
    run("R9", 1'b0, 0, 16'h0100, 0, 1'b1, 1'b1, 1'b0);
    run("R9", 1'b1, 1, 16'h0100, 0, 1'b1, 1'b1, 1'b0);
    ind_dig = 16'h0150; ind_pg = 0; ind_mode = 1;
    run("R9", 1'b0, 0, 16'h0100, 0, 1'b1, 1'b1, 1'b0);
    run("R6", 1'b0, 0, 16'h0100, 0, 1'b1, 1'b1, 1'b1);
    ind_dig = 16'h0000; ind_pg = 2; ind_mode = 1;
    run("R5", 1'b0, 0, 16'h0100, 0, 1'b1, 1'b1, 1'b0);
    ind_dig = 16'h9950; ind_pg = 1; ind_mode = 0;
    idx_dig = 16'h0075; idx_pg = 0;
    run("R9", 1'b0, 2, 16'h0200, 1, 1'b1, 1'b1, 1'b0);
    idx_dig = 16'h0010; idx_pg = 1;
    run("R9", 1'b0, 2, 16'h0200, 3, 1'b1, 1'b0, 1'b0);

    // R10 bad digits in fetched words
    ind_dig = 16'h12A4; ind_pg = 0; ind_mode = 0;
    run("R10", 1'b0, 0, 16'h0100, 1, 1'b1, 1'b1, 1'b0);
    idx_dig = 16'h00F0;
    run("R10", 1'b0, 0, 16'h0100, 2, 1'b0, 1'b1, 1'b0);

    // R12 pointer at region end
    ind_dig = 16'h0001; ind_pg = 0; ind_mode = 0;
    run("R12", 1'b0, 2, 16'h9997, 0, 1'b1, 1'b1, 1'b0);
    run("R12", 1'b0, 2, 16'h9996, 0, 1'b1, 1'b1, 1'b0);
    run("R12", 1'b1, 1, 16'h9997, 0, 1'b1, 1'b1, 1'b0);
    run("R11", 1'b1, 1, 16'h9996, 0, 1'b1, 1'b1, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule